// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Processor Status Register

This block is the execute datapath of a small 16-bit RISC core together with the core's status register. An operation code, two operands and a width select are presented with a valid strobe. The block returns the result in the same cycle, along with a write-back enable that tells the register file whether to keep it. On the next clock edge the carry, zero, negative and overflow flags are folded into the status register. Every operation runs in word width (the default, `byte_sel` low) or byte width. In byte width only the low eight bits take part, and the flags come from those eight bits.

The status register also holds the interrupt-enable bit and four low-power control bits. These are driven straight out to the clock controller and the interrupt logic. Software loads the register through a separate write port. An ALU flag update never touches the interrupt-enable or power bits. When a software write and a flag update fall in the same cycle, the software write takes effect and the flag update is dropped.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_code` 0 (add), the result is `opnd_a + opnd_b` truncated to the selected width. C is the carry out of the top bit of that width and V is set on signed overflow.
- R2: With `op_code` 1 (subtract), the result is `opnd_a + ~opnd_b + 1` in the selected width. C=1 means no borrow occurred and V flags signed overflow.
- R3: With `op_code` 2 (compare), the flags are updated exactly as for subtract, but `result_wr` stays low.
- R4: With `op_code` 3/4/5 (AND/OR/XOR), the result is the bitwise function of the operands. C is set to the inverse of Z and V is cleared.
- R5: Z is set when the result in the selected width is zero and cleared otherwise. N equals the top bit of the selected width (bit 7 or bit 15).
- R6: With `byte_sel`=1, only bits 7:0 of the operands are used and result bits 15:8 are zero. With `byte_sel`=0 the full 16 bits are used.
- R7: Status register layout: C=bit0, Z=bit1, N=bit2, interrupt enable=bit3, CPU off=bit4, oscillator off=bit5, clock gate 0=bit6, clock gate 1=bit7, V=bit8. A flag update appears on `sr_q` one clock after the operation, and bits 7:3 are left unchanged by it.
- R8: When `sr_wr_en` is high, `sr_q` takes `sr_wr_data` one clock later with bits 15:9 forced to zero. This happens even if a flag update is requested in the same cycle. Bits 15:9 always read zero.
- R9: With `op_valid` low or with `op_code` 6 or 7, the status register does not change and `result_wr` is low.
- R10: `irq_en` follows bit 3, and `cpu_off`, `osc_off`, `sclk_gate0` and `sclk_gate1` follow bits 4 to 7. `all_active` is high exactly when bits 7:4 are all clear.
- R11: While `rst_n` is low, the status register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6/7 unused |
| byte_sel | input | 1 | 1 = byte width, 0 = word width |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| sr_wr_en | input | 1 | Software write of the status register |
| sr_wr_data | input | 16 | Value for the software write |
| result | output | 16 | Operation result (same cycle) |
| result_wr | output | 1 | Result is to be written back |
| sr_q | output | 16 | Status register contents |
| irq_en | output | 1 | Maskable interrupts enabled |
| cpu_off | output | 1 | CPU clock off request |
| osc_off | output | 1 | Oscillator off request |
| sclk_gate0 | output | 1 | System clock control 0 |
| sclk_gate1 | output | 1 | System clock control 1 |
| all_active | output | 1 | No power-down bit set |

## Verification
`result` and `result_wr` are combinational. The bench therefore samples them shortly after driving the inputs on the falling edge, within the same cycle. Flags, direct writes and the decoded power outputs pass through one register, so they are due one edge later. The bench compares them at the following falling edge against a reference model that commits its own next state at the rising edge in between. Directed vectors cover the carry, borrow and overflow boundaries in both widths, and the collision of a software write with a flag update. A long random run then keeps the same per-cycle comparison.

// File: rtl/afu_pkg.sv
package afu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMP  = 3'd2,
      OP_AND  = 3'd3,
      OP_OR   = 3'd4,
      OP_XOR  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } afu_op_e;

   localparam int unsigned SR_C      = 0;
   localparam int unsigned SR_Z      = 1;
   localparam int unsigned SR_N      = 2;
   localparam int unsigned SR_IE     = 3;
   localparam int unsigned SR_CPUOFF = 4;
   localparam int unsigned SR_OSCOFF = 5;
   localparam int unsigned SR_SCG0   = 6;
   localparam int unsigned SR_SCG1   = 7;
   localparam int unsigned SR_V      = 8;
   localparam int unsigned SR_USED   = 9;

   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } afu_flags_t;

   function automatic logic op_is_arith(afu_op_e o);
      return (o == OP_ADD) || (o == OP_SUB) || (o == OP_CMP);
   endfunction

   function automatic logic op_is_logic(afu_op_e o);
      return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
   endfunction

   function automatic logic op_sets_flags(afu_op_e o);
      return op_is_arith(o) || op_is_logic(o);
   endfunction

   function automatic logic op_writes_back(afu_op_e o);
      return op_sets_flags(o) && (o != OP_CMP);
   endfunction

endpackage

// File: rtl/afu_addsub.sv
module afu_addsub #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NARROW_W = 8,
   parameter bit          RIPPLE   = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              c_nar,
   output logic              c_full,
   output logic              v_nar,
   output logic              v_full
);

   logic [DATA_W-1:0] bx;

   initial begin
      assert (NARROW_W >= 2 && NARROW_W < DATA_W)
         else $error("afu_addsub: NARROW_W must lie in [2, DATA_W)");
   end

   assign bx = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ bx[i] ^ cy[i];
            assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
         end
         assign c_nar  = cy[NARROW_W];
         assign c_full = cy[DATA_W];
      end else begin : g_flat
         logic [DATA_W:0] tot;
         assign tot    = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, sub};
         assign sum    = tot[DATA_W-1:0];
         assign c_full = tot[DATA_W];
         // carry into the first bit above the narrow lane
         assign c_nar  = tot[NARROW_W] ^ a[NARROW_W] ^ bx[NARROW_W];
      end
   endgenerate

   assign v_nar  = (a[NARROW_W-1] == bx[NARROW_W-1]) && (sum[NARROW_W-1] != a[NARROW_W-1]);
   assign v_full = (a[DATA_W-1] == bx[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);

endmodule

// File: rtl/afu_bitwise.sv
module afu_bitwise
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  afu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/afu_flagsel.sv
module afu_flagsel
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  afu_op_e           op,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] arith_sum,
   input  logic [DATA_W-1:0] logic_y,
   input  logic              c_nar,
   input  logic              c_full,
   input  logic              v_nar,
   input  logic              v_full,
   output logic [DATA_W-1:0] result,
   output afu_flags_t        flags
);

   localparam int unsigned UPPER_W = DATA_W - NARROW_W;

   logic [DATA_W-1:0] raw;
   logic              is_logic;

   assign is_logic = op_is_logic(op);
   assign raw      = is_logic ? logic_y : arith_sum;

   always_comb begin
      if (byte_sel) begin
         result = {{UPPER_W{1'b0}}, raw[NARROW_W-1:0]};
      end else begin
         result = raw;
      end
      flags.z = (result == '0);
      flags.n = byte_sel ? raw[NARROW_W-1] : raw[DATA_W-1];
      if (is_logic) begin
         flags.c = ~flags.z;
         flags.v = 1'b0;
      end else begin
         flags.c = byte_sel ? c_nar : c_full;
         flags.v = byte_sel ? v_nar : v_full;
      end
   end

endmodule

// File: rtl/afu_status.sv
module afu_status
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_en,
   input  afu_flags_t        flags_in,
   output logic [DATA_W-1:0] sr
);

   localparam logic [DATA_W-1:0] USED_MASK =
      {{(DATA_W - SR_USED){1'b0}}, {SR_USED{1'b1}}};

   logic [DATA_W-1:0] sr_next;

   initial begin
      assert (DATA_W >= SR_USED)
         else $error("afu_status: DATA_W too narrow for the status layout");
   end

   always_comb begin
      sr_next = sr;
      if (wr_en) begin
         sr_next = wr_data & USED_MASK;
      end else if (upd_en) begin
         sr_next[SR_C] = flags_in.c;
         sr_next[SR_Z] = flags_in.z;
         sr_next[SR_N] = flags_in.n;
         sr_next[SR_V] = flags_in.v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else begin
         sr <= sr_next;
      end
   end

   // R8: software write wins and reserved bits are cleared
   p_direct_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (sr == ($past(wr_data) & USED_MASK)));

   // R8: reserved bits never become set
   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sr & ~USED_MASK) == '0);

   // R7: a flag update leaves interrupt-enable and power bits alone
   p_ctrl_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en) |=> (sr[SR_SCG1:SR_IE] == $past(sr[SR_SCG1:SR_IE])));

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NARROW_W = 8,
   parameter bit          RIPPLE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              sr_wr_en,
   input  logic [DATA_W-1:0] sr_wr_data,
   output logic [DATA_W-1:0] result,
   output logic              result_wr,
   output logic [DATA_W-1:0] sr_q,
   output logic              irq_en,
   output logic              cpu_off,
   output logic              osc_off,
   output logic              sclk_gate0,
   output logic              sclk_gate1,
   output logic              all_active
);

   afu_op_e           op;
   logic              is_sub;
   logic [DATA_W-1:0] arith_sum;
   logic [DATA_W-1:0] logic_y;
   logic              c_nar, c_full, v_nar, v_full;
   afu_flags_t        flags;
   logic              upd_en;

   assign op     = afu_op_e'(op_code);
   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   afu_addsub #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W),
      .RIPPLE   (RIPPLE)
   ) i_addsub (
      .a      (opnd_a),
      .b      (opnd_b),
      .sub    (is_sub),
      .sum    (arith_sum),
      .c_nar  (c_nar),
      .c_full (c_full),
      .v_nar  (v_nar),
      .v_full (v_full)
   );

   afu_bitwise #(
      .DATA_W (DATA_W)
   ) i_bitwise (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (logic_y)
   );

   afu_flagsel #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) i_flagsel (
      .op        (op),
      .byte_sel  (byte_sel),
      .arith_sum (arith_sum),
      .logic_y   (logic_y),
      .c_nar     (c_nar),
      .c_full    (c_full),
      .v_nar     (v_nar),
      .v_full    (v_full),
      .result    (result),
      .flags     (flags)
   );

   assign upd_en    = op_valid && op_sets_flags(op);
   assign result_wr = op_valid && op_writes_back(op);

   afu_status #(
      .DATA_W (DATA_W)
   ) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sr_wr_en),
      .wr_data  (sr_wr_data),
      .upd_en   (upd_en),
      .flags_in (flags),
      .sr       (sr_q)
   );

   assign irq_en     = sr_q[SR_IE];
   assign cpu_off    = sr_q[SR_CPUOFF];
   assign osc_off    = sr_q[SR_OSCOFF];
   assign sclk_gate0 = sr_q[SR_SCG0];
   assign sclk_gate1 = sr_q[SR_SCG1];
   assign all_active = ~|sr_q[SR_SCG1:SR_CPUOFF];

   // R3: compare never requests write-back
   p_cmp_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd2) |-> !result_wr);

   // R4: after a logic update, C is the inverse of Z and V is clear
   p_logic_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !sr_wr_en && op_code inside {3'd3, 3'd4, 3'd5})
      |=> (sr_q[SR_C] == !sr_q[SR_Z]) && !sr_q[SR_V]);

   // R6: byte width leaves the upper result bits clear
   p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_sel) |-> (result[DATA_W-1:NARROW_W] == '0));

   // R9: idle or unused codes leave the register unchanged
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_wr_en && (!op_valid || op_code > 3'd5)) |=> $stable(sr_q));

endmodule

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        byte_sel = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic        sr_wr_en = 1'b0;
   logic [15:0] sr_wr_data = '0;
   logic [15:0] result, sr_q;
   logic        result_wr, irq_en, cpu_off, osc_off, sclk_gate0, sclk_gate1, all_active;

   int n_chk = 0;
   int n_err = 0;
   logic [15:0] model_sr = '0;
   int prev_kind = 0; // 0 idle, 1 alu update, 2 software write

   always #10 clk = ~clk;

   arith_flag_unit i_arith_flag_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .byte_sel(byte_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .result(result),
      .result_wr(result_wr), .sr_q(sr_q), .irq_en(irq_en), .cpu_off(cpu_off),
      .osc_off(osc_off), .sclk_gate0(sclk_gate0), .sclk_gate1(sclk_gate1),
      .all_active(all_active)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_sr();
      string tag;
      tag = (prev_kind == 2) ? "R8 write" : (prev_kind == 1) ? "R7 update" : "R9 hold";
      check(sr_q == model_sr, tag, sr_q, model_sr);
      if (prev_kind == 1)
         check(sr_q[2:1] == model_sr[2:1], "R5 Z/N", {14'd0, sr_q[2:1]}, {14'd0, model_sr[2:1]});
      check({irq_en, cpu_off, osc_off, sclk_gate0, sclk_gate1} ==
            {model_sr[3], model_sr[4], model_sr[5], model_sr[6], model_sr[7]},
            "R10 outputs", {11'd0, irq_en, cpu_off, osc_off, sclk_gate0, sclk_gate1},
            {11'd0, model_sr[3], model_sr[4], model_sr[5], model_sr[6], model_sr[7]});
      check(all_active == (model_sr[7:4] == 4'd0), "R10 all_active",
            {15'd0, all_active}, {15'd0, model_sr[7:4] == 4'd0});
   endtask

   task automatic step(input bit v, input logic [2:0] op, input bit bs,
                       input logic [15:0] a, input logic [15:0] b,
                       input bit we, input logic [15:0] wd);
      int w, msk, aa, bb, s, res, c, z, n, ov;
      bit wr, upd;
      string tag;
      logic [15:0] nxt;
      @(negedge clk);
      check_sr();
      op_valid = v; op_code = op; byte_sel = bs; opnd_a = a; opnd_b = b;
      sr_wr_en = we; sr_wr_data = wd;
      #1;
      w = bs ? 8 : 16;
      msk = (1 << w) - 1;
      aa = int'(a) & msk;
      bb = int'(b) & msk;
      c = 0; ov = 0; res = 0;
      case (op)
         3'd0: begin
            s = aa + bb; res = s & msk; c = (s >> w) & 1;
            ov = (((aa >> (w-1)) & 1) == ((bb >> (w-1)) & 1)) &&
                 (((res >> (w-1)) & 1) != ((aa >> (w-1)) & 1));
         end
         3'd1, 3'd2: begin
            s = aa + ((~bb) & msk) + 1; res = s & msk; c = (s >> w) & 1;
            ov = (((aa >> (w-1)) & 1) != ((bb >> (w-1)) & 1)) &&
                 (((res >> (w-1)) & 1) != ((aa >> (w-1)) & 1));
         end
         3'd3: res = aa & bb;
         3'd4: res = aa | bb;
         3'd5: res = aa ^ bb;
         default: res = 0;
      endcase
      z = (res == 0);
      n = (res >> (w-1)) & 1;
      if (op >= 3'd3 && op <= 3'd5) begin c = !z; ov = 0; end
      upd = v && (op <= 3'd5);
      wr  = upd && (op != 3'd2);
      tag = (op == 3'd0) ? "R1 add" : (op == 3'd1) ? "R2 sub" :
            (op == 3'd2) ? "R3 cmp" : (op <= 3'd5) ? "R4 logic" : "R9 unused";
      check(result_wr == wr, tag, {15'd0, result_wr}, {15'd0, wr});
      if (wr) begin
         if (bs) tag = "R6 byte";
         check(result == res[15:0], tag, result, res[15:0]);
      end
      nxt = model_sr;
      if (we) begin
         nxt = wd & 16'h01FF; prev_kind = 2;
      end else if (upd) begin
         nxt[0] = c[0]; nxt[1] = z[0]; nxt[2] = n[0]; nxt[8] = ov[0]; prev_kind = 1;
      end else begin
         prev_kind = 0;
      end
      @(posedge clk);
      model_sr = nxt;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sr_q == 16'h0000, "R11 reset", sr_q, 16'h0000);
      check(all_active == 1'b1, "R11 reset", {15'd0, all_active}, 16'h0001);
      rst_n = 1'b1;
      // R1 word overflow and carry
      step(1, 3'd0, 0, 16'h7FFF, 16'h0001, 0, 16'h0);
      step(1, 3'd0, 0, 16'hFFFF, 16'h0001, 0, 16'h0);
      // R6 byte add ignores upper bits
      step(1, 3'd0, 1, 16'h12FF, 16'h3401, 0, 16'h0);
      // R2 byte signed overflow, word borrow
      step(1, 3'd1, 1, 16'h0080, 16'h0001, 0, 16'h0);
      step(1, 3'd1, 0, 16'h0000, 16'h0001, 0, 16'h0);
      // R3 compare equal
      step(1, 3'd2, 0, 16'h5A5A, 16'h5A5A, 0, 16'h0);
      // R4 logic
      step(1, 3'd3, 0, 16'hF0F0, 16'h0F0F, 0, 16'h0);
      step(1, 3'd5, 0, 16'hF0F0, 16'h0F0F, 0, 16'h0);
      step(1, 3'd4, 1, 16'hFF00, 16'h0080, 0, 16'h0);
      // R8 software write sets all bits, reserved cleared
      step(0, 3'd0, 0, 16'h0, 16'h0, 1, 16'hFFFF);
      // R7 update keeps control bits
      step(1, 3'd0, 0, 16'h0001, 16'h0001, 0, 16'h0);
      // R8 write wins over a simultaneous update
      step(1, 3'd0, 0, 16'hFFFF, 16'h0001, 1, 16'h0008);
      // R9 idle and unused codes
      step(1, 3'd6, 0, 16'h0, 16'h0, 0, 16'h0);
      step(1, 3'd7, 1, 16'hFFFF, 16'hFFFF, 0, 16'h0);
      step(0, 3'd0, 0, 16'hFFFF, 16'h0001, 0, 16'h0);
      for (int k = 0; k < 4000; k++) begin
         step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              16'($urandom), 16'($urandom), $urandom_range(0, 15) == 0, 16'($urandom));
      end
      @(negedge clk);
      check_sr();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule